// File: doc/BRIEF.md
# Frame-Difference Motion Centroid Tracker

This block finds where something moved between two consecutive frames of a small colour video stream. For each raster position the host presents one pixel pair: the colour value from the current frame and the colour value at the same position in the previous frame. The block reduces each pixel to an 8-bit gray level and takes the absolute difference of the two gray levels. A pixel whose difference is above a threshold counts as moving. For the moving pixels the block accumulates the coordinate sums, the count, and the extreme coordinates.

When the last pixel pair of the frame has been accepted, a sequential divider computes the centre of mass of the moving pixels. The block then presents that point and the enclosing box on its result outputs, and it raises an interrupt. A start pulse loads the threshold and begins a frame. The same pulse also acknowledges the interrupt left by the previous frame. Pixel pairs enter through a valid/ready handshake, so an upstream queue can stall the block at any point.

Top module: `motion_centroid_tracker`

## Requirements
- R1: After a synchronous reset, irq, pix_ready and res_valid are 0, and cen_x, cen_y and all four box outputs are 0.
- R2: Each 24-bit pixel carries red in bits 23:16, green in 15:8 and blue in 7:0, and its gray level is floor((77*red + 150*green + 29*blue) / 256).
- R3: A pixel pair is moving when the absolute difference of its two gray levels is strictly greater than the threshold. The threshold is taken from thresh_in in the cycle of an accepted start pulse.
- R4: Pixels are assigned raster coordinates in acceptance order: column 0 to COLS-1 first, then the next row. pix_ready is high only while a frame is being accumulated, and it falls once COLS*ROWS pairs have been accepted.
- R5: A pixel pair is consumed only in a cycle where pix_valid and pix_ready are both high. Idle cycles on pix_valid lose no data and do not change the result.
- R6: When at least one pixel moved, cen_x and cen_y are the floor of the summed column and row of the moving pixels divided by their count.
- R7: When at least one pixel moved, box_x_lo/box_x_hi and box_y_lo/box_y_hi are the smallest and largest column and row among the moving pixels.
- R8: When no pixel moved, res_valid is 0 and the centroid and box outputs keep their previous values.
- R9: irq rises when the result is ready and stays high until a start pulse. That pulse clears irq and begins a new frame in the following cycle.
- R10: A start pulse during accumulation or division is ignored: it neither restarts the frame nor changes the threshold.
- R11: The result outputs change only in the cycle where irq rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame; also acknowledges irq |
| thresh_in | input | 8 | Motion threshold, sampled on an accepted start |
| pix_valid | input | 1 | Pixel pair present |
| pix_ready | output | 1 | Block is taking pixel pairs |
| pix_cur | input | 24 | Current-frame pixel, RGB 8:8:8 |
| pix_prev | input | 24 | Previous-frame pixel at the same position |
| irq | output | 1 | Result ready, held until next start |
| res_valid | output | 1 | At least one moving pixel in the last frame |
| cen_x | output | clog2(COLS) | Centroid column |
| cen_y | output | clog2(ROWS) | Centroid row |
| box_x_lo | output | clog2(COLS) | Leftmost moving column |
| box_x_hi | output | clog2(COLS) | Rightmost moving column |
| box_y_lo | output | clog2(ROWS) | Topmost moving row |
| box_y_hi | output | clog2(ROWS) | Bottom moving row |

## Verification
If the raster position counter slips, the pixel count is wrong and pix_ready falls early or late. The box also shifts by whole columns, and both show up at the end of the first affected frame. A stale threshold, an accumulator that was not cleared, or a divider that stops one step short all produce a wrong centroid or box at the next irq. Frames with a known rectangle of motion expose each of these faults. A start pulse that is wrongly honoured mid-frame shows up as a frame that never completes on schedule, or as results computed with the wrong threshold.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int CH_W = 8;
  localparam int W_RED = 77;
  localparam int W_GRN = 150;
  localparam int W_BLU = 29;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_ACCUM  = 2'd1,
    S_DIVIDE = 2'd2,
    S_DONE   = 2'd3
  } fsm_t;
endpackage

// File: rtl/mct_luma.sv
module mct_luma
  import mct_pkg::*;
(
  input  rgb_t            px,
  output logic [CH_W-1:0] gray
);
  localparam int ACC_W = CH_W + 8;

  logic [ACC_W-1:0] wsum;

  always_comb begin
    wsum = ACC_W'(px.r) * ACC_W'(W_RED)
         + ACC_W'(px.g) * ACC_W'(W_GRN)
         + ACC_W'(px.b) * ACC_W'(W_BLU);
    gray = wsum[ACC_W-1:8];
  end
endmodule

// File: rtl/mct_accum.sv
module mct_accum #(
  parameter int COLS = 160,
  parameter int ROWS = 120,
  localparam int X_W   = $clog2(COLS),
  localparam int Y_W   = $clog2(ROWS),
  localparam int NPIX  = COLS * ROWS,
  localparam int CNT_W = $clog2(NPIX + 1),
  localparam int SX_W  = X_W + CNT_W,
  localparam int SY_W  = Y_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             hit,
  output logic             at_end,
  output logic [SX_W-1:0]  sum_x,
  output logic [SY_W-1:0]  sum_y,
  output logic [CNT_W-1:0] count,
  output logic [X_W-1:0]   min_x,
  output logic [X_W-1:0]   max_x,
  output logic [Y_W-1:0]   min_y,
  output logic [Y_W-1:0]   max_y
);
  localparam logic [X_W-1:0] X_LAST = X_W'(COLS - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(ROWS - 1);

  logic [X_W-1:0] xpos;
  logic [Y_W-1:0] ypos;

  assign at_end = (xpos == X_LAST) && (ypos == Y_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      xpos  <= '0;
      ypos  <= '0;
      sum_x <= '0;
      sum_y <= '0;
      count <= '0;
      min_x <= X_LAST;
      max_x <= '0;
      min_y <= Y_LAST;
      max_y <= '0;
    end else if (step) begin
      if (xpos == X_LAST) begin
        xpos <= '0;
        ypos <= (ypos == Y_LAST) ? '0 : ypos + 1'b1;
      end else begin
        xpos <= xpos + 1'b1;
      end
      if (hit) begin
        sum_x <= sum_x + SX_W'(xpos);
        sum_y <= sum_y + SY_W'(ypos);
        count <= count + 1'b1;
        if (xpos < min_x) min_x <= xpos;
        if (xpos > max_x) max_x <= xpos;
        if (ypos < min_y) min_y <= ypos;
        if (ypos > max_y) max_y <= ypos;
      end
    end
  end
endmodule

// File: rtl/mct_divu.sv
module mct_divu #(
  parameter int NUM_W = 22,
  parameter int DEN_W = 15,
  parameter int Q_W   = 8,
  localparam int STEP_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   quo
);
  logic [DEN_W:0]      rem;
  logic [DEN_W-1:0]    den_q;
  logic [NUM_W-1:0]    qreg;
  logic [STEP_W-1:0]   steps;
  logic                running;
  logic [DEN_W:0]      trial;
  logic [DEN_W:0]      less;
  logic                fits;

  always_comb begin
    trial = {rem[DEN_W-1:0], qreg[NUM_W-1]};
    fits  = trial >= {1'b0, den_q};
    less  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem     <= '0;
      den_q   <= '0;
      qreg    <= '0;
      steps   <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem     <= '0;
        den_q   <= den;
        qreg    <= num;
        steps   <= STEP_W'(NUM_W);
        running <= 1'b1;
      end else if (running) begin
        rem   <= fits ? less : trial;
        qreg  <= {qreg[NUM_W-2:0], fits};
        steps <= steps - 1'b1;
        if (steps == STEP_W'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  assign quo = qreg[Q_W-1:0];
endmodule

// File: rtl/motion_centroid_tracker.sv
module motion_centroid_tracker
  import mct_pkg::*;
#(
  parameter int COLS = 160,
  parameter int ROWS = 120,
  localparam int X_W = $clog2(COLS),
  localparam int Y_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CH_W-1:0]   thresh_in,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [3*CH_W-1:0] pix_cur,
  input  logic [3*CH_W-1:0] pix_prev,
  output logic              irq,
  output logic              res_valid,
  output logic [X_W-1:0]    cen_x,
  output logic [Y_W-1:0]    cen_y,
  output logic [X_W-1:0]    box_x_lo,
  output logic [X_W-1:0]    box_x_hi,
  output logic [Y_W-1:0]    box_y_lo,
  output logic [Y_W-1:0]    box_y_hi
);
  localparam int NPIX  = COLS * ROWS;
  localparam int CNT_W = $clog2(NPIX + 1);
  localparam int SX_W  = X_W + CNT_W;
  localparam int SY_W  = Y_W + CNT_W;
  localparam int SUM_W = (SX_W > SY_W) ? SX_W : SY_W;

  fsm_t            state;
  logic [CH_W-1:0] thr_q;
  logic            kick;

  // gray conversion of both frames
  rgb_t            px_in [2];
  logic [CH_W-1:0] lum   [2];
  assign px_in[0] = pix_cur;
  assign px_in[1] = pix_prev;

  for (genvar g = 0; g < 2; g++) begin : g_luma
    mct_luma u_luma (.px(px_in[g]), .gray(lum[g]));
  end

  logic [CH_W-1:0] absdiff;
  logic            hit;
  logic            take;
  logic            start_ok;

  assign absdiff   = (lum[0] >= lum[1]) ? (lum[0] - lum[1]) : (lum[1] - lum[0]);
  assign hit       = absdiff > thr_q;
  assign pix_ready = (state == S_ACCUM);
  assign take      = pix_valid && pix_ready;
  assign start_ok  = start && ((state == S_IDLE) || (state == S_DONE));

  logic             at_end;
  logic [SX_W-1:0]  sum_x;
  logic [SY_W-1:0]  sum_y;
  logic [CNT_W-1:0] count;
  logic [X_W-1:0]   min_x, max_x;
  logic [Y_W-1:0]   min_y, max_y;

  mct_accum #(.COLS(COLS), .ROWS(ROWS)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .clear (start_ok),
    .step  (take),
    .hit   (hit),
    .at_end(at_end),
    .sum_x (sum_x),
    .sum_y (sum_y),
    .count (count),
    .min_x (min_x),
    .max_x (max_x),
    .min_y (min_y),
    .max_y (max_y)
  );

  logic           div_go;
  logic           done_x, done_y;
  logic [X_W-1:0] qx;
  logic [Y_W-1:0] qy;

  assign div_go = (state == S_DIVIDE) && kick && (count != '0);

  mct_divu #(.NUM_W(SUM_W), .DEN_W(CNT_W), .Q_W(X_W)) u_div_x (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num (SUM_W'(sum_x)),
    .den (count),
    .done(done_x),
    .quo (qx)
  );

  mct_divu #(.NUM_W(SUM_W), .DEN_W(CNT_W), .Q_W(Y_W)) u_div_y (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num (SUM_W'(sum_y)),
    .den (count),
    .done(done_y),
    .quo (qy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      thr_q     <= '0;
      kick      <= 1'b0;
      irq       <= 1'b0;
      res_valid <= 1'b0;
      cen_x     <= '0;
      cen_y     <= '0;
      box_x_lo  <= '0;
      box_x_hi  <= '0;
      box_y_lo  <= '0;
      box_y_hi  <= '0;
    end else begin
      kick <= 1'b0;
      unique case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            thr_q <= thresh_in;
            irq   <= 1'b0;
            state <= S_ACCUM;
          end
        end
        S_ACCUM: begin
          if (take && at_end) begin
            kick  <= 1'b1;
            state <= S_DIVIDE;
          end
        end
        S_DIVIDE: begin
          if (kick && (count == '0)) begin
            res_valid <= 1'b0;
            irq       <= 1'b1;
            state     <= S_DONE;
          end else if (done_x && done_y) begin
            res_valid <= 1'b1;
            cen_x     <= qx;
            cen_y     <= qy;
            box_x_lo  <= min_x;
            box_x_hi  <= max_x;
            box_y_lo  <= min_y;
            box_y_hi  <= max_y;
            irq       <= 1'b1;
            state     <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int COLS = 160,
  parameter int ROWS = 120,
  localparam int X_W = $clog2(COLS),
  localparam int Y_W = $clog2(ROWS)
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           pix_valid,
  input logic           pix_ready,
  input logic           irq,
  input logic           res_valid,
  input logic [X_W-1:0] cen_x,
  input logic [Y_W-1:0] cen_y,
  input logic [X_W-1:0] box_x_lo,
  input logic [X_W-1:0] box_x_hi,
  input logic [Y_W-1:0] box_y_lo,
  input logic [Y_W-1:0] box_y_hi
);
  AST_READY_NOT_IRQ: assert property (@(posedge clk) disable iff (rst)
    !(pix_ready && irq)); // R4

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !start) |=> irq); // R9

  AST_ACK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (irq && start) |=> (!irq && pix_ready)); // R9

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (pix_ready && start && !pix_valid) |=> pix_ready); // R10

  AST_BOX_ORDERED: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((box_x_lo <= box_x_hi) && (box_y_lo <= box_y_hi))); // R7

  AST_CENTROID_IN_BOX: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((cen_x >= box_x_lo) && (cen_x <= box_x_hi) &&
                   (cen_y >= box_y_lo) && (cen_y <= box_y_hi))); // R6

  AST_RESULT_ONLY_AT_IRQ: assert property (@(posedge clk) disable iff (rst)
    !$rose(irq) |-> ($stable(cen_x) && $stable(cen_y) && $stable(res_valid) &&
                     $stable(box_x_lo) && $stable(box_x_hi) &&
                     $stable(box_y_lo) && $stable(box_y_hi))); // R11
endmodule

bind motion_centroid_tracker mct_checker #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .pix_valid(pix_valid),
  .pix_ready(pix_ready),
  .irq      (irq),
  .res_valid(res_valid),
  .cen_x    (cen_x),
  .cen_y    (cen_y),
  .box_x_lo (box_x_lo),
  .box_x_hi (box_x_hi),
  .box_y_lo (box_y_lo),
  .box_y_hi (box_y_hi)
);

// File: tb/motion_centroid_tracker_tb_top.sv
module motion_centroid_tracker_tb_top;
  localparam int TC  = 8;
  localparam int TR  = 6;
  localparam int NP  = TC * TR;
  localparam int XW  = $clog2(TC);
  localparam int YW  = $clog2(TR);

  // {thr, base, delta, darker, x0:x1, y0:y1}
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    48'h0A_32_14_00_13_12,
    48'h0A_64_1E_01_07_05,
    48'h14_28_14_00_24_13,
    48'h13_28_14_00_57_35,
    48'h00_00_01_01_77_55,
    48'hC8_0A_F0_00_00_00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] thresh_in = '0;
  logic pix_valid = 1'b0;
  logic pix_ready;
  logic [23:0] pix_cur = '0;
  logic [23:0] pix_prev = '0;
  logic irq, res_valid;
  logic [XW-1:0] cen_x, box_x_lo, box_x_hi;
  logic [YW-1:0] cen_y, box_y_lo, box_y_hi;

  always #2 clk = ~clk;

  motion_centroid_tracker #(.COLS(TC), .ROWS(TR)) dut_i (
    .clk(clk), .rst(rst), .start(start), .thresh_in(thresh_in),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_cur(pix_cur), .pix_prev(pix_prev),
    .irq(irq), .res_valid(res_valid), .cen_x(cen_x), .cen_y(cen_y),
    .box_x_lo(box_x_lo), .box_x_hi(box_x_hi),
    .box_y_lo(box_y_lo), .box_y_hi(box_y_hi)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [23:0] cur_mem [NP];
  logic [23:0] prev_mem [NP];
  int e_valid, e_cx, e_cy, e_xl, e_xh, e_yl, e_yh;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int luma(input logic [23:0] p);
    return (int'(p[23:16]) * 77 + int'(p[15:8]) * 150 + int'(p[7:0]) * 29) / 256;
  endfunction

  task automatic clear_expect();
    e_valid = 0; e_cx = 0; e_cy = 0; e_xl = 0; e_xh = 0; e_yl = 0; e_yh = 0;
  endtask

  task automatic fill_rect(input int base, input int delta, input int darker,
                           input int x0, input int x1, input int y0, input int y1);
    for (int i = 0; i < NP; i++) begin
      int x = i % TC;
      int y = i / TC;
      logic [7:0] lo = 8'(base);
      logic [7:0] hi = 8'(base + delta);
      if (x >= x0 && x <= x1 && y >= y0 && y <= y1) begin
        cur_mem[i]  = darker ? {lo, lo, lo} : {hi, hi, hi};
        prev_mem[i] = darker ? {hi, hi, hi} : {lo, lo, lo};
      end else begin
        cur_mem[i]  = {lo, lo, lo};
        prev_mem[i] = {lo, lo, lo};
      end
    end
  endtask

  // reference model built from R2, R3, R6, R7, R8
  task automatic model(input int thr);
    int sx = 0, sy = 0, n = 0;
    int xl = TC, xh = -1, yl = TR, yh = -1;
    for (int i = 0; i < NP; i++) begin
      int d = luma(cur_mem[i]) - luma(prev_mem[i]);
      if (d < 0) d = -d;
      if (d > thr) begin
        int x = i % TC;
        int y = i / TC;
        sx += x; sy += y; n++;
        if (x < xl) xl = x;
        if (x > xh) xh = x;
        if (y < yl) yl = y;
        if (y > yh) yh = y;
      end
    end
    if (n == 0) begin
      e_valid = 0;
    end else begin
      e_valid = 1; e_cx = sx / n; e_cy = sy / n;
      e_xl = xl; e_xh = xh; e_yl = yl; e_yh = yh;
    end
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R8 res_valid"}, int'(res_valid), e_valid);
    chk({tag, " R6 cen_x"}, int'(cen_x), e_cx);
    chk({tag, " R6 cen_y"}, int'(cen_y), e_cy);
    chk({tag, " R7 box_x_lo"}, int'(box_x_lo), e_xl);
    chk({tag, " R7 box_x_hi"}, int'(box_x_hi), e_xh);
    chk({tag, " R7 box_y_lo"}, int'(box_y_lo), e_yl);
    chk({tag, " R7 box_y_hi"}, int'(box_y_hi), e_yh);
  endtask

  task automatic run_frame(input string tag, input int thr, input bit stall, input bit midstart);
    int idx = 0;
    int cyc = 0;
    int waitn = 0;
    bit mid_sent = 0;
    @(negedge clk);
    start = 1'b1; thresh_in = 8'(thr);
    @(negedge clk);
    start = 1'b0; thresh_in = 8'hFF;
    chk({tag, " R9 irq cleared by start"}, int'(irq), 0);
    chk({tag, " R9 ready after start"}, int'(pix_ready), 1);
    while (idx < NP && cyc < 5000) begin
      pix_valid = !(stall && (cyc % 3 == 1));
      pix_cur  = cur_mem[idx];
      pix_prev = prev_mem[idx];
      if (midstart && idx == NP / 2 && !mid_sent) begin
        start = 1'b1;  // R10: must be ignored
        mid_sent = 1;
      end else begin
        start = 1'b0;
      end
      if (pix_valid && pix_ready) idx++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    pix_cur = 24'hFFFFFF; pix_prev = 24'h000000;  // surplus pair, R4
    chk({tag, " R4 ready low after last pixel"}, int'(pix_ready), 0);
    chk({tag, " R11 old result held"}, int'(cen_x), e_cx);
    chk({tag, " R11 old valid held"}, int'(res_valid), e_valid);
    while (!irq && waitn < 400) begin
      @(negedge clk);
      waitn++;
    end
    pix_valid = 1'b0;
    chk({tag, " R9 irq raised"}, int'(irq), 1);
    model(thr);
    check_outputs(tag);
  endtask

  initial begin
    clear_expect();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 pix_ready", int'(pix_ready), 0);
    check_outputs("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R4 idle not ready", int'(pix_ready), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [47:0] e = VEC[v];
      fill_rect(int'(e[39:32]), int'(e[31:24]), int'(e[16]),
                int'(e[15:12]), int'(e[11:8]), int'(e[7:4]), int'(e[3:0]));
      run_frame($sformatf("vec%0d R3", v), int'(e[47:40]), 1'b0, 1'b0);
    end

    // R9 irq held while no start arrives
    repeat (6) @(negedge clk);
    chk("R9 irq held", int'(irq), 1);
    chk("R9 not ready while done", int'(pix_ready), 0);

    // R2 colour weighting: red->76, green->149, blue->28
    for (int i = 0; i < NP; i++) begin
      cur_mem[i] = 24'h0; prev_mem[i] = 24'h0;
    end
    cur_mem[1 * TC + 2] = 24'hFF0000;
    cur_mem[4 * TC + 5] = 24'h00FF00;
    cur_mem[0 * TC + 6] = 24'h0000FF;
    run_frame("R2 colour thr100", 100, 1'b0, 1'b0);
    chk("R2 green only cen_x", int'(cen_x), 5);
    run_frame("R2 colour thr27", 27, 1'b0, 1'b0);
    chk("R2 three hits cen_x", int'(cen_x), 4);
    chk("R2 three hits box_y_hi", int'(box_y_hi), 4);
    run_frame("R2 red at threshold 76", 76, 1'b0, 1'b0);
    run_frame("R2 red above 75", 75, 1'b0, 1'b0);

    // R5 stalls, R10 start during accumulation
    fill_rect(60, 40, 0, 2, 5, 1, 4);
    run_frame("R5 stalled", 30, 1'b1, 1'b0);
    fill_rect(60, 40, 1, 0, 3, 2, 5);
    run_frame("R10 midstart", 30, 1'b1, 1'b1);

    // R1 reset in the middle of a frame
    @(negedge clk);
    start = 1'b1; thresh_in = 8'd5;
    @(negedge clk);
    start = 1'b0;
    pix_valid = 1'b1;
    repeat (5) @(negedge clk);
    pix_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_expect();
    chk("R1 mid reset irq", int'(irq), 0);
    chk("R1 mid reset ready", int'(pix_ready), 0);
    check_outputs("R1 mid reset");
    fill_rect(20, 50, 0, 7, 7, 0, 5);
    run_frame("R4 after reset column7", 10, 1'b0, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule